// File: doc/BRIEF.md
# Stack Bytecode Execution Unit

This block interprets a small subset of stack-machine bytecode directly in hardware. After a start pulse it reads a byte-wide code memory one location per clock, beginning at a given address. It decodes each byte and acts on a 16-entry operand stack of 32-bit signed integers and a small bank of local-variable registers. The supported operations are pushing an inline byte, pushing zero, loading and storing locals, integer addition and return. Opcodes that carry an inline argument take one extra code location, and so one extra cycle.

Execution stops in one of two ways. A return opcode raises a one-cycle completion pulse. A stack overflow, a stack underflow or an unsupported opcode sets a sticky error flag and leaves the stack and the locals as they were before the faulting operation. A debug port reads any local register by index, the top of the stack and the current stack depth, so that the surrounding logic can collect results.

Top module: `bcode_engine`

## Requirements
- R1: After reset, busy, done and err are low, depth is 0, tos is 0 and every local register reads 0.
- R2: A start pulse while idle begins execution at start_addr. One code location is consumed per clock, and the byte-push opcode 0x10 consumes its argument location as well. If the return opcode sits r locations after start_addr, done is high after clock edge r+1, counting the edge that sampled start as edge 0.
- R3: Opcode 0x10 pushes the following code byte sign-extended to 32 bits. Opcode 0x03 pushes zero.
- R4: Opcodes 0x3c, 0x3d and 0x3e pop the top entry into locals 1, 2 and 3. Opcodes 0x1b and 0x1c push locals 1 and 2. The depth changes by at most one per clock while running.
- R5: Opcode 0x60 pops the top two entries and pushes their sum modulo 2^32. Opcode 0xb1 raises done for exactly one cycle and returns the unit to idle with err low.
- R6: A push at depth 16 sets err and stops execution without done. The depth stays 16 and never exceeds 16.
- R7: A pop from an empty stack, or an add with fewer than two entries, sets err and stops execution. The depth and the locals are left unchanged.
- R8: Any opcode other than 0x03, 0x10, 0x1b, 0x1c, 0x3c, 0x3d, 0x3e, 0x60 and 0xb1 sets err and stops execution, and no later byte is executed. err stays high until the next accepted start, which clears it. done and err are never high together.
- R9: A start pulse while busy is ignored. While idle, the depth does not change.
- R10: dbg_local shows the local register selected by dbg_idx. tos shows the top stack entry, or 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured while idle |
| start_addr | input | AW | First code location to execute |
| code_addr | output | AW | Code memory read address |
| code_byte | input | 8 | Code byte at code_addr, same cycle |
| busy | output | 1 | High while executing |
| done | output | 1 | One-cycle pulse on return |
| err | output | 1 | Sticky fault flag |
| dbg_idx | input | log2(NLOC) | Local register select for debug read |
| dbg_local | output | DW | Selected local register value |
| tos | output | DW | Top of stack, 0 when empty |
| depth | output | log2(DEPTH+1) | Number of stack entries |

## Verification
The assertions assume that code_byte settles combinationally within the cycle for the address on code_addr, and that reset is applied before the first start. The bench models the code memory as a combinational array indexed by code_addr, and it issues every start pulse at a falling edge, for exactly one cycle. Only one start pulse in the bench falls while the unit is busy, and it is issued on purpose to check that it is ignored.

// File: rtl/bce_pkg.sv
package bce_pkg;

   localparam logic [7:0] OPC_PUSH_BYTE = 8'h10;
   localparam logic [7:0] OPC_PUSH_ZERO = 8'h03;
   localparam logic [7:0] OPC_LOAD_L1   = 8'h1b;
   localparam logic [7:0] OPC_LOAD_L2   = 8'h1c;
   localparam logic [7:0] OPC_STORE_L1  = 8'h3c;
   localparam logic [7:0] OPC_STORE_L2  = 8'h3d;
   localparam logic [7:0] OPC_STORE_L3  = 8'h3e;
   localparam logic [7:0] OPC_ADD       = 8'h60;
   localparam logic [7:0] OPC_RETURN    = 8'hb1;

   typedef enum logic [1:0] {
      SRC_ZERO,
      SRC_LOCAL,
      SRC_SUM,
      SRC_ARG
   } push_src_e;

   typedef struct packed {
      logic       push;
      logic [1:0] pop_n;
      push_src_e  src;
      logic       st_en;
      logic [1:0] lidx;
      logic       need_arg;
      logic       ret;
      logic       bad;
   } dec_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_ARG
   } run_state_e;

endpackage

// File: rtl/bce_decode.sv
module bce_decode
   import bce_pkg::*;
(
   input  logic [7:0] opc,
   output dec_t       dec
);

   always_comb begin
      dec     = '0;
      dec.src = SRC_ZERO;
      unique case (opc)
         OPC_PUSH_BYTE: dec.need_arg = 1'b1;
         OPC_PUSH_ZERO: begin
            dec.push = 1'b1;
            dec.src  = SRC_ZERO;
         end
         OPC_STORE_L1, OPC_STORE_L2, OPC_STORE_L3: begin
            dec.pop_n = 2'd1;
            dec.st_en = 1'b1;
            dec.lidx  = opc[1:0] + 2'd1;
         end
         OPC_LOAD_L1, OPC_LOAD_L2: begin
            dec.push = 1'b1;
            dec.src  = SRC_LOCAL;
            dec.lidx = opc[1:0] + 2'd2;
         end
         OPC_ADD: begin
            dec.pop_n = 2'd2;
            dec.push  = 1'b1;
            dec.src   = SRC_SUM;
         end
         OPC_RETURN: dec.ret = 1'b1;
         default:    dec.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/bce_stack.sv
module bce_stack #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   parameter int SPW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           we,
   input  logic [1:0]     pop_n,
   input  logic           push,
   input  logic [DW-1:0]  push_val,
   output logic [DW-1:0]  top0,
   output logic [DW-1:0]  top1,
   output logic [SPW-1:0] depth
);

   logic [DW-1:0]  ent [DEPTH];
   logic [SPW-1:0] sp;
   logic [SPW-1:0] wr_idx;

   assign wr_idx = sp - SPW'(pop_n);
   assign depth  = sp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
      end else if (clr) begin
         sp <= '0;
      end else if (we) begin
         sp <= wr_idx + SPW'(push);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[i] <= '0;
         end else if (we && push && (wr_idx == SPW'(i))) begin
            ent[i] <= push_val;
         end
      end
   end

   always_comb begin
      top0 = '0;
      top1 = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sp - SPW'(1) == SPW'(i)) top0 = ent[i];
         if (sp - SPW'(2) == SPW'(i)) top1 = ent[i];
      end
   end

endmodule

// File: rtl/bce_locals.sv
module bce_locals #(
   parameter int DW   = 32,
   parameter int NLOC = 4,
   parameter int LW   = $clog2(NLOC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [LW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [LW-1:0] ridx,
   output logic [DW-1:0] rdata,
   input  logic [LW-1:0] dbg_idx,
   output logic [DW-1:0] dbg_data
);

   logic [DW-1:0] loc [NLOC];

   for (genvar i = 0; i < NLOC; i++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            loc[i] <= '0;
         end else if (we && (widx == LW'(i))) begin
            loc[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata    = '0;
      dbg_data = '0;
      for (int i = 0; i < NLOC; i++) begin
         if (ridx == LW'(i))    rdata    = loc[i];
         if (dbg_idx == LW'(i)) dbg_data = loc[i];
      end
   end

endmodule

// File: rtl/bcode_engine.sv
module bcode_engine
   import bce_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int DEPTH    = 16,
   parameter int NLOC     = 4,
   parameter bit ARG_SEXT = 1'b1,
   localparam int SPW     = $clog2(DEPTH + 1),
   localparam int LW      = $clog2(NLOC)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  start_addr,
   output logic [AW-1:0]  code_addr,
   input  logic [7:0]     code_byte,
   output logic           busy,
   output logic           done,
   output logic           err,
   input  logic [LW-1:0]  dbg_idx,
   output logic [DW-1:0]  dbg_local,
   output logic [DW-1:0]  tos,
   output logic [SPW-1:0] depth
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bcode_engine: DEPTH must be at least 2");
   end
   if (NLOC < 4) begin : g_bad_nloc
      $error("bcode_engine: NLOC must be at least 4");
   end
   if (DW < 8) begin : g_bad_dw
      $error("bcode_engine: DW must be at least 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("bcode_engine: AW must be at least 1");
   end

   run_state_e    state;
   logic [AW-1:0] pc;
   dec_t          dec;

   logic          op_push;
   logic [1:0]    op_pop_n;
   push_src_e     op_src;
   logic          op_store;
   logic          active;
   logic          ovf;
   logic          unf;
   logic          fault;
   logic          exec;
   logic          clr;
   logic [DW-1:0] top0;
   logic [DW-1:0] top1;
   logic [DW-1:0] loc_rd;
   logic [DW-1:0] arg_val;
   logic [DW-1:0] push_val;

   bce_decode u_dec (
      .opc (code_byte),
      .dec (dec)
   );

   if (ARG_SEXT) begin : g_sext
      assign arg_val = {{(DW-8){code_byte[7]}}, code_byte};
   end else begin : g_zext
      assign arg_val = {{(DW-8){1'b0}}, code_byte};
   end

   always_comb begin
      if (state == ST_ARG) begin
         op_push  = 1'b1;
         op_pop_n = 2'd0;
         op_src   = SRC_ARG;
         op_store = 1'b0;
      end else begin
         op_push  = dec.push;
         op_pop_n = dec.pop_n;
         op_src   = dec.src;
         op_store = dec.st_en;
      end
   end

   assign active = (state != ST_IDLE);
   assign ovf    = op_push && (op_pop_n == 2'd0) && (depth == SPW'(DEPTH));
   assign unf    = (depth < SPW'(op_pop_n));
   assign fault  = active && (ovf || unf || ((state == ST_RUN) && dec.bad));
   assign exec   = active && !fault;
   assign clr    = (state == ST_IDLE) && start;

   always_comb begin
      unique case (op_src)
         SRC_ZERO:  push_val = '0;
         SRC_LOCAL: push_val = loc_rd;
         SRC_SUM:   push_val = top0 + top1;
         default:   push_val = arg_val;
      endcase
   end

   bce_stack #(
      .DW    (DW),
      .DEPTH (DEPTH),
      .SPW   (SPW)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .we       (exec),
      .pop_n    (op_pop_n),
      .push     (op_push),
      .push_val (push_val),
      .top0     (top0),
      .top1     (top1),
      .depth    (depth)
   );

   bce_locals #(
      .DW   (DW),
      .NLOC (NLOC),
      .LW   (LW)
   ) u_locals (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (exec && op_store),
      .widx     (LW'(dec.lidx)),
      .wdata    (top0),
      .ridx     (LW'(dec.lidx)),
      .rdata    (loc_rd),
      .dbg_idx  (dbg_idx),
      .dbg_data (dbg_local)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pc    <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_RUN;
                  pc    <= start_addr;
                  err   <= 1'b0;
               end
            end
            ST_RUN: begin
               if (fault) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else if (dec.ret) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  pc <= pc + AW'(1);
                  if (dec.need_arg) state <= ST_ARG;
               end
            end
            default: begin
               if (fault) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  pc    <= pc + AW'(1);
                  state <= ST_RUN;
               end
            end
         endcase
      end
   end

   assign code_addr = pc;
   assign busy      = active;
   assign tos       = top0;

endmodule

// File: rtl/bce_chk.sv
module bce_chk #(
   parameter int DEPTH = 16,
   parameter int SPW   = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           err,
   input logic [SPW-1:0] depth
);

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   a_r8_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !err);

   a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= SPW'(DEPTH));

   a_r4_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((depth <= $past(depth) + SPW'(1)) && ($past(depth) <= depth + SPW'(1))));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(depth));

endmodule

bind bcode_engine bce_chk #(
   .DEPTH (DEPTH),
   .SPW   (SPW)
) i_bce_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .err   (err),
   .depth (depth)
);

// File: tb/test_bcode_engine.sv
`timescale 1ns/1ps
module test_bcode_engine;

   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam int SPW = 5;
   localparam int LW  = 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           start;
   logic [AW-1:0]  start_addr;
   logic [AW-1:0]  code_addr;
   logic [7:0]     code_byte;
   logic           busy;
   logic           done;
   logic           err;
   logic [LW-1:0]  dbg_idx;
   logic [DW-1:0]  dbg_local;
   logic [DW-1:0]  tos;
   logic [SPW-1:0] depth;

   logic [7:0] mem [256];
   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   assign code_byte = mem[code_addr];

   bcode_engine i_bcode_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (start_addr),
      .code_addr  (code_addr),
      .code_byte  (code_byte),
      .busy       (busy),
      .done       (done),
      .err        (err),
      .dbg_idx    (dbg_idx),
      .dbg_local  (dbg_local),
      .tos        (tos),
      .depth      (depth)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         n_bad = n_bad + 1;
         $display("FAIL R2 watchdog: actual=hang expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(inout int a, input logic [7:0] b);
      mem[a] = b;
      a = a + 1;
   endtask

   task automatic rd_local(input int idx, output logic [31:0] v);
      dbg_idx = LW'(idx);
      #0.5;
      v = dbg_local;
   endtask

   // Start at addr; a second start to 0x20 is pulsed at cycle intr (0 = none).
   task automatic go(input logic [7:0] addr, input int intr, output int n, output int dc);
      n  = 0;
      dc = 0;
      @(negedge clk);
      start_addr = addr;
      start      = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      do begin
         @(posedge clk);
         n = n + 1;
         @(negedge clk);
         if (done) dc = dc + 1;
         if (intr != 0 && n == intr) begin
            start_addr = 8'h20;
            start      = 1'b1;
         end else begin
            start = 1'b0;
         end
      end while (busy && n < 200);
      start = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 busy", 32'(busy), 0);
      check("R1 done", 32'(done), 0);
      check("R1 err", 32'(err), 0);
      check("R1 depth", 32'(depth), 0);
      check("R1 tos", tos, 0);
      rd_local(3, v);
      check("R1 local3", v, 0);
   endtask

   task automatic t_sample();
      int a = 8'h20;
      int n, dc;
      logic [31:0] v;
      put(a, 8'h10); put(a, 8'h0f); put(a, 8'h3c);
      put(a, 8'h10); put(a, 8'h09); put(a, 8'h3d);
      put(a, 8'h03); put(a, 8'h3e);
      put(a, 8'h1b); put(a, 8'h1c); put(a, 8'h60); put(a, 8'h3e);
      put(a, 8'hb1);
      go(8'h20, 0, n, dc);
      check("R2 cycles to done", n, 13);
      check("R5 done pulses", dc, 1);
      check("R5 err low", 32'(err), 0);
      check("R5 idle after return", 32'(busy), 0);
      @(negedge clk);
      check("R5 done one cycle", 32'(done), 0);
      rd_local(1, v); check("R4 local1", v, 15);
      rd_local(2, v); check("R4 local2", v, 9);
      rd_local(3, v); check("R5 local3 sum", v, 24);
      rd_local(0, v); check("R10 local0", v, 0);
      check("R4 depth empty", 32'(depth), 0);
      check("R10 tos empty", tos, 0);
   endtask

   task automatic t_negsum();
      int a = 8'h40;
      int n, dc;
      logic [31:0] v;
      put(a, 8'h10); put(a, 8'hfb); put(a, 8'h10); put(a, 8'h03);
      put(a, 8'h60); put(a, 8'h3c); put(a, 8'h1b); put(a, 8'hb1);
      go(8'h40, 0, n, dc);
      check("R2 cycles negsum", n, 8);
      rd_local(1, v); check("R3 negative sum local1", v, 32'hffff_fffe);
      check("R10 tos negsum", tos, 32'hffff_fffe);
      check("R4 depth negsum", 32'(depth), 1);
   endtask

   task automatic t_sext();
      int a = 8'h50;
      int n, dc;
      put(a, 8'h10); put(a, 8'h80); put(a, 8'hb1);
      go(8'h50, 0, n, dc);
      check("R3 sign extend", tos, 32'hffff_ff80);
      check("R3 depth", 32'(depth), 1);
   endtask

   task automatic t_load_order();
      int a = 8'h58;
      int n, dc;
      put(a, 8'h10); put(a, 8'h05); put(a, 8'h3d);
      put(a, 8'h10); put(a, 8'h07); put(a, 8'h3c);
      put(a, 8'h1c); put(a, 8'h1b); put(a, 8'hb1);
      go(8'h58, 0, n, dc);
      check("R4 load order tos", tos, 7);
      check("R4 load order depth", 32'(depth), 2);
   endtask

   task automatic t_overflow();
      int a = 8'h70;
      int n, dc;
      for (int k = 0; k < 17; k++) put(a, 8'h03);
      put(a, 8'hb1);
      go(8'h70, 0, n, dc);
      check("R6 overflow err", 32'(err), 1);
      check("R6 no done", dc, 0);
      check("R6 depth held", 32'(depth), 16);
      check("R6 fault cycle", n, 17);
      repeat (3) @(negedge clk);
      check("R8 err sticky", 32'(err), 1);
   endtask

   task automatic t_underflow();
      int a = 8'h90;
      int n, dc;
      logic [31:0] v;
      put(a, 8'h03); put(a, 8'h60); put(a, 8'hb1);
      go(8'h90, 0, n, dc);
      check("R7 add underflow err", 32'(err), 1);
      check("R7 add depth", 32'(depth), 1);
      check("R7 fault cycle", n, 2);
      a = 8'h98;
      put(a, 8'h3e); put(a, 8'hb1);
      go(8'h98, 0, n, dc);
      check("R7 store underflow err", 32'(err), 1);
      check("R7 no done", dc, 0);
      check("R7 store depth", 32'(depth), 0);
      rd_local(3, v); check("R7 local3 kept", v, 24);
   endtask

   task automatic t_illegal();
      int a = 8'ha0;
      int n, dc;
      logic [31:0] v;
      put(a, 8'h10); put(a, 8'h09); put(a, 8'h00); put(a, 8'h3d); put(a, 8'hb1);
      go(8'ha0, 0, n, dc);
      check("R8 illegal err", 32'(err), 1);
      check("R8 fault cycle", n, 3);
      check("R8 no done", dc, 0);
      check("R8 tos", tos, 9);
      rd_local(2, v); check("R8 later byte not run", v, 5);
      go(8'h50, 0, n, dc);
      check("R8 err cleared by start", 32'(err), 0);
   endtask

   task automatic t_busy_start();
      int a = 8'hc0;
      int n, dc;
      logic [31:0] v;
      put(a, 8'h10); put(a, 8'h01); put(a, 8'h3c);
      put(a, 8'h03); put(a, 8'h03); put(a, 8'h03); put(a, 8'h03);
      put(a, 8'h60); put(a, 8'h60); put(a, 8'h60); put(a, 8'h3d);
      put(a, 8'hb1);
      go(8'hc0, 2, n, dc);
      check("R9 run not restarted", n, 12);
      check("R9 single done", dc, 1);
      rd_local(1, v); check("R9 local1", v, 1);
      rd_local(2, v); check("R9 local2", v, 0);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 8'hff;
      rst_n      = 1'b0;
      start      = 1'b0;
      start_addr = '0;
      dbg_idx    = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sample();
      t_negsum();
      t_sext();
      t_load_order();
      t_overflow();
      t_underflow();
      t_illegal();
      t_busy_start();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule